// File: doc/BRIEF.md
# Merged Enable/Status Interrupt Collector

This block collects a small group of level or pulse interrupt sources into one level-sensitive request toward a parent interrupt controller. Each source owns two bits of a single 32-bit control word: an enable bit in the lower half and a latched status bit in the upper half. A source's status bit always sits exactly 16 positions above its enable bit. The group of sources starts at a parameterised base bit, so one netlist can serve several slots of a shared control word.

A status bit is latched when its raw input goes from low to high, whether or not the source is enabled. Software clears a status bit by writing 1 to it. Writing 0 to a status bit leaves it alone, so a write that only updates enables passes zeros in the upper half. The output request is high while any source has both its status and its enable bit set. It stays high until software clears every such status bit or disables the sources concerned. Software normally services pending sources from the lowest bit upward, clearing one status bit per write.

Register access is a plain valid/write strobe with full-word writes. A read returns the merged word one cycle later. That return path is a two-state access machine: ACC_IDLE moves to ACC_RESP when a read is requested (transition "read accepted"). ACC_RESP stays in ACC_RESP on a further read ("read chained") and returns to ACC_IDLE otherwise ("response done"). Reset forces ACC_IDLE.

Top module: `irq_merge_ctl`

## Requirements
- R1: Reset (asynchronous, active low) clears every enable and status bit, holds irq_out low, rd_valid low and the access machine in ACC_IDLE.
- R2: For source k (0 ≤ k < N_SRC), the enable bit is word bit BASE_BIT+k and the status bit is word bit BASE_BIT+k+16. A read returns the word in this layout.
- R3: Word bits outside the configured enable and status ranges always read as 0, and writes to them have no effect.
- R4: Writing 1 to a configured status bit clears it. Writing 0 to it leaves it unchanged, so an enable-only write with bits 31:16 all zero never clears status.
- R5: Every write loads each configured enable bit from its position in the written word.
- R6: A source is pending when its status and enable bits are both 1. irq_out is high exactly when at least one source is pending, and a status bit whose enable is 0 never drives irq_out.
- R7: irq_out is a level. Once high, it stays high across cycles without a write, and it falls only after writes clear the pending status bits or disable those sources.
- R8: A low-to-high transition on raw_irq[k] sets status bit k at the next clock edge, whether or not the source is enabled. A raw input held high does not set the bit again after it is cleared.
- R9: When a rising raw edge and a write-1 clear hit the same status bit in the same cycle, the bit ends up set.
- R10: A read request (reg_valid high, reg_write low) gives rd_valid high for exactly the next cycle, with rd_data holding the word as it stood at the request edge. A write never raises rd_valid.
- R11: When several sources are pending and software clears them one at a time in ascending bit order, irq_out stays high until the last pending bit is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read, qualified by reg_valid |
| reg_wdata | input | 32 | Full word written to the control register |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 32 | Merged enable/status word |
| raw_irq | input | N_SRC | Raw interrupt inputs, synchronous to clk |
| irq_out | output | 1 | Level request to the parent controller |

## Verification
The assertions assume that raw_irq is already synchronous to clk and holds steady between edges. They also assume that reg_valid, reg_write and reg_wdata are stable around each rising edge. The edge-latch and set-over-clear properties compare raw_irq with its value one cycle earlier, so they rely on the inputs being sampled exactly once per cycle. The bench changes every input only on the falling clock edge and samples outputs there too, so each edge sees one settled set of values. Raw inputs are held at zero through reset, so the edge history the properties use starts from a known state.

// File: rtl/irq_merge_ctl_pkg.sv
package irq_merge_ctl_pkg;

    localparam int WORD_W   = 32;
    localparam int STAT_OFS = 16;

    typedef enum logic [0:0] {
        ACC_IDLE = 1'b0,
        ACC_RESP = 1'b1
    } acc_state_e;

    typedef logic [WORD_W-1:0] word_t;

endpackage

// File: rtl/irq_merge_edge.sv
module irq_merge_edge #(
    parameter int N_SRC = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] raw_in,
    output logic [N_SRC-1:0] rise
);

    logic [N_SRC-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= raw_in;
        end
    end

    genvar g;
    generate
        for (g = 0; g < N_SRC; g++) begin : g_rise
            assign rise[g] = raw_in[g] & ~prev_q[g];
        end
    endgenerate

endmodule

// File: rtl/irq_merge_bank.sv
module irq_merge_bank #(
    parameter int N_SRC = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [N_SRC-1:0] wr_enable,
    input  logic [N_SRC-1:0] wr_clear,
    input  logic [N_SRC-1:0] rise,
    output logic [N_SRC-1:0] en_q,
    output logic [N_SRC-1:0] stat_q
);

    genvar g;
    generate
        for (g = 0; g < N_SRC; g++) begin : g_src
            logic clr_hit;
            assign clr_hit = wr_en & wr_clear[g];

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    en_q[g] <= 1'b0;
                end else if (wr_en) begin
                    en_q[g] <= wr_enable[g];
                end
            end

            // a new edge takes precedence over a same-cycle clear
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stat_q[g] <= 1'b0;
                end else if (rise[g]) begin
                    stat_q[g] <= 1'b1;
                end else if (clr_hit) begin
                    stat_q[g] <= 1'b0;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/irq_merge_access.sv
module irq_merge_access
    import irq_merge_ctl_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  rd_req,
    input  word_t word_in,
    output logic  rd_valid,
    output word_t rd_data
);

    acc_state_e state_q;
    acc_state_e state_d;
    word_t      hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ACC_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACC_IDLE: state_d = rd_req ? ACC_RESP : ACC_IDLE;
            ACC_RESP: state_d = rd_req ? ACC_RESP : ACC_IDLE;
            default:  state_d = ACC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (rd_req) begin
            hold_q <= word_in;
        end
    end

    always_comb begin
        rd_valid = 1'b0;
        rd_data  = '0;
        unique case (state_q)
            ACC_IDLE: begin
                rd_valid = 1'b0;
                rd_data  = '0;
            end
            ACC_RESP: begin
                rd_valid = 1'b1;
                rd_data  = hold_q;
            end
            default: begin
                rd_valid = 1'b0;
                rd_data  = '0;
            end
        endcase
    end

endmodule

// File: rtl/irq_merge_ctl.sv
module irq_merge_ctl
    import irq_merge_ctl_pkg::*;
#(
    parameter int N_SRC    = 7,
    parameter int BASE_BIT = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_valid,
    input  logic             reg_write,
    input  logic [31:0]      reg_wdata,
    output logic             rd_valid,
    output logic [31:0]      rd_data,
    input  logic [N_SRC-1:0] raw_irq,
    output logic             irq_out
);

    localparam int EN_LO   = BASE_BIT;
    localparam int STAT_LO = BASE_BIT + STAT_OFS;

    initial begin
        if (N_SRC < 1 || BASE_BIT < 0 || BASE_BIT + N_SRC > STAT_OFS) begin
            $error("irq_merge_ctl: sources must fit inside the lower half word");
        end
    end

    logic             wr_en;
    logic             rd_req;
    logic [N_SRC-1:0] rise;
    logic [N_SRC-1:0] en_q;
    logic [N_SRC-1:0] stat_q;
    word_t            word_now;
    logic             unused_wbits;

    assign wr_en        = reg_valid & reg_write;
    assign rd_req       = reg_valid & ~reg_write;
    assign unused_wbits = ^reg_wdata;

    irq_merge_edge #(.N_SRC(N_SRC)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_in (raw_irq),
        .rise   (rise)
    );

    irq_merge_bank #(.N_SRC(N_SRC)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_enable (reg_wdata[EN_LO +: N_SRC]),
        .wr_clear  (reg_wdata[STAT_LO +: N_SRC]),
        .rise      (rise),
        .en_q      (en_q),
        .stat_q    (stat_q)
    );

    always_comb begin
        word_now                    = '0;
        word_now[EN_LO +: N_SRC]    = en_q;
        word_now[STAT_LO +: N_SRC]  = stat_q;
    end

    assign irq_out = |(en_q & stat_q);

    irq_merge_access u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_req   (rd_req),
        .word_in  (word_now),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/irq_merge_ctl_chk.sv
module irq_merge_ctl_chk #(
    parameter int N_SRC    = 7,
    parameter int BASE_BIT = 0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_valid,
    input logic             reg_write,
    input logic [31:0]      reg_wdata,
    input logic             rd_valid,
    input logic [31:0]      rd_data,
    input logic [N_SRC-1:0] raw_irq,
    input logic             irq_out,
    input logic [N_SRC-1:0] en_q,
    input logic [N_SRC-1:0] stat_q
);

    localparam logic [31:0] SRC_MASK = (32'd1 << N_SRC) - 32'd1;
    localparam logic [31:0] LEGAL    = (SRC_MASK << BASE_BIT) | (SRC_MASK << (BASE_BIT + 16));

    // R1: coming out of reset nothing is requested or returned
    p_reset_quiet_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (!irq_out && !rd_valid));

    // R3: unconfigured bits never appear in read data
    p_read_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ((rd_data & ~LEGAL) == 32'h0));

    // R4: a write with an all-zero status half keeps every latched bit
    p_enable_only_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && reg_write && (reg_wdata[31:16] == 16'h0))
        |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

    // R6: with every source disabled the request is low
    p_masked_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !irq_out);

    // R7: without a write the level request cannot drop
    p_level_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && !(reg_valid && reg_write)) |=> irq_out);

    // R10: read strobe yields data valid next cycle, anything else does not
    p_read_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && !reg_write) |=> rd_valid);
    p_no_spurious_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_valid && !reg_write) |=> !rd_valid);

    genvar g;
    generate
        for (g = 0; g < N_SRC; g++) begin : g_src_chk
            // R8 and R9: a rising raw edge always leaves the status bit set
            p_edge_sets_r8_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (raw_irq[g] && !$past(raw_irq[g])) |=> stat_q[g]);
        end
    endgenerate

endmodule

bind irq_merge_ctl irq_merge_ctl_chk #(.N_SRC(N_SRC), .BASE_BIT(BASE_BIT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_valid (reg_valid),
    .reg_write (reg_write),
    .reg_wdata (reg_wdata),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .raw_irq   (raw_irq),
    .irq_out   (irq_out),
    .en_q      (en_q),
    .stat_q    (stat_q)
);

// File: tb/tb_irq_merge_ctl.sv
`timescale 1ns/1ps
module tb_irq_merge_ctl;

    localparam int N   = 7;
    localparam int NV  = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_valid = 1'b0;
    logic         reg_write = 1'b0;
    logic [31:0]  reg_wdata = '0;
    logic         rd_valid;
    logic [31:0]  rd_data;
    logic [N-1:0] raw_irq = '0;
    logic         irq_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    irq_merge_ctl #(.N_SRC(N), .BASE_BIT(0)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_valid (reg_valid),
        .reg_write (reg_write),
        .reg_wdata (reg_wdata),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .raw_irq   (raw_irq),
        .irq_out   (irq_out)
    );

    // fields: [79:76] write flag, [75:44] write data, [43:36] raw inputs,
    //         [35:32] expected irq_out, [31:0] expected read word
    localparam logic [79:0] VEC [NV] = '{
        80'h0_00000000_00_0_00000000,  // idle, nothing pending
        80'h0_00000000_05_0_00050000,  // R8 edges latch while disabled, R6 masked
        80'h1_00000004_05_1_00050004,  // R5 enable src2, R6 request
        80'h1_00000005_05_1_00050005,  // R4 enable-only write keeps status
        80'h1_00010005_05_1_00040005,  // R4 clear src0 first, R11
        80'h1_00040005_05_0_00000005,  // R4 clear src2, R8 held raw no re-set
        80'h0_00000000_00_0_00000005,  // raw falls, nothing changes
        80'h0_00000000_40_0_00400005,  // R8 src6 latched, disabled
        80'h1_FF80FFC0_40_1_00400040,  // R3 out-of-range bits ignored, R2 layout
        80'h1_00000000_40_0_00400000,  // R7 disabling drops request
        80'h1_007F007F_40_0_0000007F,  // R4 clear all, enable all
        80'h0_00000000_7F_1_003F007F   // R8 only new edges latch
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic step(input bit wr, input logic [31:0] wd, input logic [N-1:0] raw);
        raw_irq   = raw;
        reg_valid = wr;
        reg_write = wr;
        reg_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        reg_valid = 1'b0;
        reg_write = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic rd(output logic v, output logic [31:0] w);
        reg_valid = 1'b1;
        reg_write = 1'b0;
        @(posedge clk);
        @(negedge clk);
        reg_valid = 1'b0;
        v = rd_valid;
        w = rd_data;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic        v;
        logic [31:0] w;
        logic [N-1:0] raw_now;

        repeat (3) @(negedge clk);
        // R1: outputs during reset
        check("R1 irq_out in reset", {31'h0, irq_out}, 32'h0);
        check("R1 rd_valid in reset", {31'h0, rd_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(v, w);
        check("R1 reset word", w, 32'h0);
        @(negedge clk);
        check("R10 rd_valid one cycle only", {31'h0, rd_valid}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [79:0] e;
            e = VEC[i];
            step(e[76], e[75:44], e[42:36]);
            check($sformatf("R6 vector %0d irq_out", i), {31'h0, irq_out}, {31'h0, e[32]});
            if (e[76]) check($sformatf("R10 vector %0d no rd_valid on write", i),
                             {31'h0, rd_valid}, 32'h0);
            rd(v, w);
            check($sformatf("R10 vector %0d rd_valid", i), {31'h0, v}, 32'h1);
            check($sformatf("R2 vector %0d word", i), w, e[31:0]);
        end

        // R9: rising edge on src0 and a clear of src0 and src1 in the same cycle
        step(1'b0, 32'h0, 7'h7E);
        step(1'b1, 32'h0003007F, 7'h7F);
        rd(v, w);
        check("R9 set wins over clear", w, 32'h003D007F);
        check("R9 irq_out", {31'h0, irq_out}, 32'h1);

        // R11: clear pending bits one by one, lowest first
        raw_now = 7'h7F;
        for (int b = 0; b < N; b++) begin
            if (b != 1 && b != 6) begin
                step(1'b1, (32'h1 << (16 + b)) | 32'h7F, raw_now);
                check($sformatf("R11 irq_out after clearing src%0d", b), {31'h0, irq_out},
                      (b == 5) ? 32'h0 : 32'h1);
            end
        end
        rd(v, w);
        check("R11 all cleared word", w, 32'h0000007F);

        // R1: reset in mid-run with a pending source
        step(1'b0, 32'h0, 7'h00);
        step(1'b0, 32'h0, 7'h01);
        check("R6 pending before reset", {31'h0, irq_out}, 32'h1);
        rst_n = 1'b0;
        #1;
        check("R1 async reset drops irq_out", {31'h0, irq_out}, 32'h0);
        raw_irq = '0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(v, w);
        check("R1 word after mid-run reset", w, 32'h0);

        done = 1'b1;
        finish_run();
    end

endmodule